// File: doc/BRIEF.md
# Instruction Cache Control and Event Counter Front End

This block is the register-side front end of an instruction cache and its companion line buffer. It holds the settings the cache engine needs: cache enable, line-buffer enable, replacement-policy select and count enable. It also turns software requests into one-cycle flush pulses for the engine. The cache array, the replacement logic and the fetch path sit elsewhere. The engine sends back a busy level and one pulse per hit and per miss.

Software reaches the block through a simple word-addressed register bus. A write is a single-cycle strobe, and read data is combinational from the address. The control word can be changed only while the cache is idle. Two saturating event counters count the engine's hit and miss pulses while counting is enabled. Software can zero both counters with one control write. A status word reports the engine's busy state, and it reports the enabled state once the engine has settled.

Top module: `icache_ctrl_regs`

## Requirements
- R1: A control write (address 0) made while status busy is 1 is dropped. The control word, the enable outputs and the counters are left unchanged, and no flush pulse is produced.
- R2: The readable control fields are cache enable at bit 0, line-buffer enable at bit 4, replacement policy at bit 6 and count enable at bit 7. They reset to 1, 1, 0 and 1, so the control word reads 0x91 after reset. They drive `cache_en`, `lbuf_en` and `repl_sel`. The write-only bits 3, 5, 8 and 16 always read as 0.
- R3: An accepted control write with bit 3, 5 or 16 set raises `flush_cache`, `flush_lbuf` or `flush_port2` respectively for exactly the one cycle after the write. Writing 0 to those bits produces no pulse.
- R4: An accepted write that changes cache enable from 1 to 0 pulses `flush_cache`. One that changes line-buffer enable from 1 to 0 pulses `flush_lbuf`. Writing 0 to an enable that is already 0 gives no pulse, and neither does raising an enable.
- R5: An accepted control write with bit 8 set zeroes both counters. This takes priority over a hit or miss event in the same cycle. A control write with bit 8 clear leaves the counters as they are.
- R6: Each `ev_hit` or `ev_miss` cycle adds one to the hit counter (address 2) or the miss counter (address 3) while count enable is 1. While count enable is 0, the counters hold.
- R7: A counter that has reached all ones stays at all ones on further events.
- R8: Status (address 1) has busy at bit 1 and enabled at bit 0, and both reset to 1. Busy equals `eng_busy` as sampled at the previous clock edge. Enabled takes the cache-enable setting only at edges where `eng_busy` is low, and holds its value otherwise.
- R9: Writes to addresses 1, 2 and 3 have no effect on any register or output. Reads of addresses 0 to 3 return control, status, hit count and miss count, zero-extended to 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 2 | Word address: 0 control, 1 status, 2 hits, 3 misses |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| eng_busy | input | 1 | Cache engine is changing state |
| ev_hit | input | 1 | One pulse per cache hit |
| ev_miss | input | 1 | One pulse per cache miss |
| cache_en | output | 1 | Cache enable setting |
| lbuf_en | output | 1 | Line-buffer enable setting |
| repl_sel | output | 1 | Replacement policy select |
| flush_cache | output | 1 | One-cycle cache flush request |
| flush_lbuf | output | 1 | One-cycle line-buffer flush request |
| flush_port2 | output | 1 | One-cycle flush request for the second port's cache |

## Verification
Every register in the block is a single stage. A control write or an event presented in cycle N therefore takes effect at the next edge: the enables, the counters and the read data show it from cycle N+1, and a flush pulse is high in cycle N+1 only. A status change follows `eng_busy` by that same one edge. The driver records every expectation with the cycle number in which the result is due: N+1 for a pulse and N+2 for its return to 0. A monitor samples at the falling edge and checks only the entries due in that cycle. Reads are due in the cycle in which the address is driven.

// File: rtl/icc_pkg.sv
package icc_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 2;

    // control word bit positions
    localparam int CTL_EN     = 0;
    localparam int CTL_CFLUSH = 3;
    localparam int CTL_LEN    = 4;
    localparam int CTL_LFLUSH = 5;
    localparam int CTL_POL    = 6;
    localparam int CTL_CNTEN  = 7;
    localparam int CTL_CNTCLR = 8;
    localparam int CTL_PFLUSH = 16;

    typedef enum logic [ADDR_W-1:0] {
        ICC_A_CTRL = 2'd0,
        ICC_A_STAT = 2'd1,
        ICC_A_HIT  = 2'd2,
        ICC_A_MISS = 2'd3
    } icc_addr_e;

    typedef struct packed {
        logic cnt_en;
        logic repl;
        logic lbuf_en;
        logic cache_en;
    } icc_ctrl_t;

    typedef struct packed {
        logic port2;
        logic lbuf;
        logic cache;
    } icc_flush_t;

    localparam icc_ctrl_t CTRL_RST = '{cnt_en: 1'b1, repl: 1'b0, lbuf_en: 1'b1, cache_en: 1'b1};

    function automatic logic [DATA_W-1:0] ctrl_word(input icc_ctrl_t c);
        logic [DATA_W-1:0] w;
        w            = '0;
        w[CTL_EN]    = c.cache_en;
        w[CTL_LEN]   = c.lbuf_en;
        w[CTL_POL]   = c.repl;
        w[CTL_CNTEN] = c.cnt_en;
        return w;
    endfunction

    function automatic icc_ctrl_t ctrl_from_word(input logic [DATA_W-1:0] w);
        icc_ctrl_t c;
        c.cache_en = w[CTL_EN];
        c.lbuf_en  = w[CTL_LEN];
        c.repl     = w[CTL_POL];
        c.cnt_en   = w[CTL_CNTEN];
        return c;
    endfunction

endpackage

// File: rtl/icc_ctrl_reg.sv
module icc_ctrl_reg
    import icc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_req,
    input  logic [DATA_W-1:0] wdata,
    input  logic              busy,
    output icc_ctrl_t         ctrl_o,
    output icc_flush_t        flush_o,
    output logic              clr_o
);

    icc_ctrl_t  ctrl_q;
    icc_flush_t flush_q;
    icc_flush_t flush_d;
    logic       accept;

    assign accept = wr_req & ~busy;
    assign clr_o  = accept & wdata[CTL_CNTCLR];

    always_comb begin
        flush_d = '0;
        if (accept) begin
            flush_d.cache = wdata[CTL_CFLUSH] | (ctrl_q.cache_en & ~wdata[CTL_EN]);
            flush_d.lbuf  = wdata[CTL_LFLUSH] | (ctrl_q.lbuf_en & ~wdata[CTL_LEN]);
            flush_d.port2 = wdata[CTL_PFLUSH];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= CTRL_RST;
            flush_q <= '0;
        end else begin
            flush_q <= flush_d;
            if (accept) ctrl_q <= ctrl_from_word(wdata);
        end
    end

    assign ctrl_o  = ctrl_q;
    assign flush_o = flush_q;

    // R1: busy blocks the control word and all pulses
    a_r1_write_dropped: assert property (@(posedge clk) disable iff (rst)
        (wr_req && busy) |=> (ctrl_q == $past(ctrl_q)) && (flush_q == '0));

    // R3: a pulse only ever follows an accepted write
    a_r3_pulse_after_write: assert property (@(posedge clk) disable iff (rst)
        (flush_q != '0) |-> $past(accept));

    // R4: disabling the cache flushes it
    a_r4_disable_flush: assert property (@(posedge clk) disable iff (rst)
        (accept && ctrl_q.cache_en && !wdata[CTL_EN]) |=> flush_q.cache);

endmodule

// File: rtl/icc_sat_counter.sv
module icc_sat_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         inc_en,
    input  logic         evt,
    output logic [W-1:0] cnt
);

    localparam logic [W-1:0] CNT_MAX = '1;
    localparam logic [W-1:0] CNT_ONE = W'(1);

    logic at_max;
    assign at_max = (cnt == CNT_MAX);

    always_ff @(posedge clk) begin
        if (rst || clr)                cnt <= '0;
        else if (inc_en && evt && !at_max) cnt <= cnt + CNT_ONE;
    end

    // R5: clear wins over a simultaneous event
    a_r5_clear_wins: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt == '0));

    // R6: without a counted event the value holds
    a_r6_hold: assert property (@(posedge clk) disable iff (rst)
        (!clr && !(inc_en && evt)) |=> $stable(cnt));

    // R7: all ones is sticky until a clear
    a_r7_saturate: assert property (@(posedge clk) disable iff (rst)
        (at_max && !clr) |=> (cnt == CNT_MAX));

endmodule

// File: rtl/icc_status.sv
module icc_status (
    input  logic clk,
    input  logic rst,
    input  logic eng_busy,
    input  logic cache_en,
    output logic busy_o,
    output logic en_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_o <= 1'b1;
            en_o   <= 1'b1;
        end else begin
            busy_o <= eng_busy;
            if (!eng_busy) en_o <= cache_en;
        end
    end

    // R8: busy trails the engine by one edge
    a_r8_busy_follow: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (busy_o == $past(eng_busy)));

    // R8: enabled bit frozen while the engine is busy
    a_r8_en_frozen: assert property (@(posedge clk) disable iff (rst)
        eng_busy |=> $stable(en_o));

endmodule

// File: rtl/icache_ctrl_regs.sv
module icache_ctrl_regs
    import icc_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              eng_busy,
    input  logic              ev_hit,
    input  logic              ev_miss,
    output logic              cache_en,
    output logic              lbuf_en,
    output logic              repl_sel,
    output logic              flush_cache,
    output logic              flush_lbuf,
    output logic              flush_port2
);

    localparam int N_CNT = 2;

    icc_ctrl_t        ctrl;
    icc_flush_t       flush;
    logic             clr;
    logic             ctrl_wr;
    logic             sts_busy;
    logic             sts_en;
    logic [N_CNT-1:0] evt;
    logic [CNT_W-1:0] cnt_q [N_CNT];
    logic [DATA_W-1:0] cnt_ext [N_CNT];

    assign ctrl_wr = bus_wr && (icc_addr_e'(bus_addr) == ICC_A_CTRL);
    assign evt     = {ev_miss, ev_hit};

    icc_status u_status (
        .clk      (clk),
        .rst      (rst),
        .eng_busy (eng_busy),
        .cache_en (ctrl.cache_en),
        .busy_o   (sts_busy),
        .en_o     (sts_en)
    );

    icc_ctrl_reg u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .wr_req  (ctrl_wr),
        .wdata   (bus_wdata),
        .busy    (sts_busy),
        .ctrl_o  (ctrl),
        .flush_o (flush),
        .clr_o   (clr)
    );

    for (genvar g = 0; g < N_CNT; g++) begin : g_cnt
        icc_sat_counter #(.W(CNT_W)) u_cnt (
            .clk    (clk),
            .rst    (rst),
            .clr    (clr),
            .inc_en (ctrl.cnt_en),
            .evt    (evt[g]),
            .cnt    (cnt_q[g])
        );
        always_comb begin
            cnt_ext[g]            = '0;
            cnt_ext[g][CNT_W-1:0] = cnt_q[g];
        end
    end

    always_comb begin
        case (icc_addr_e'(bus_addr))
            ICC_A_CTRL: bus_rdata = ctrl_word(ctrl);
            ICC_A_STAT: bus_rdata = {{(DATA_W-2){1'b0}}, sts_busy, sts_en};
            ICC_A_HIT:  bus_rdata = cnt_ext[0];
            default:    bus_rdata = cnt_ext[1];
        endcase
    end

    assign cache_en    = ctrl.cache_en;
    assign lbuf_en     = ctrl.lbuf_en;
    assign repl_sel    = ctrl.repl;
    assign flush_cache = flush.cache;
    assign flush_lbuf  = flush.lbuf;
    assign flush_port2 = flush.port2;

    // R9: a write to any other address leaves the outputs unchanged
    a_r9_other_addr: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && !ctrl_wr) |=> $stable({cache_en, lbuf_en, repl_sel})
                                 && !flush_cache && !flush_lbuf && !flush_port2);

endmodule

// File: tb/sim_icache_ctrl_regs.sv
`timescale 1ns/1ps
module sim_icache_ctrl_regs;

    localparam int KIND_FLUSH = 0;
    localparam int KIND_OUTS  = 1;
    localparam int KIND_RD    = 2;

    typedef struct {
        int          due;
        int          kind;
        logic [31:0] val;
        string       req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        eng_busy = 1'b0;
    logic        ev_hit = 1'b0;
    logic        ev_miss = 1'b0;
    logic        cache_en, lbuf_en, repl_sel;
    logic        flush_cache, flush_lbuf, flush_port2;

    int   cyc = 0;
    int   checks = 0;
    int   errors = 0;
    exp_t sb[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    icache_ctrl_regs #(.CNT_W(4)) u0 (
        .clk, .rst, .bus_wr, .bus_addr, .bus_wdata, .bus_rdata,
        .eng_busy, .ev_hit, .ev_miss, .cache_en, .lbuf_en, .repl_sel,
        .flush_cache, .flush_lbuf, .flush_port2
    );

    // monitor: compare entries due in this cycle at the falling edge
    always @(negedge clk) begin
        for (int i = sb.size() - 1; i >= 0; i--) begin
            if (sb[i].due == cyc) begin
                logic [31:0] act;
                case (sb[i].kind)
                    KIND_FLUSH: act = {29'd0, flush_port2, flush_lbuf, flush_cache};
                    KIND_OUTS:  act = {29'd0, repl_sel, lbuf_en, cache_en};
                    default:    act = bus_rdata;
                endcase
                checks++;
                if (act !== sb[i].val) begin
                    errors++;
                    $display("FAIL %s cycle %0d kind %0d: actual 0x%0h expected 0x%0h",
                             sb[i].req, cyc, sb[i].kind, act, sb[i].val);
                end
                sb.delete(i);
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic push(int due, int kind, logic [31:0] val, string req);
        exp_t e;
        e.due = due; e.kind = kind; e.val = val; e.req = req;
        sb.push_back(e);
    endtask

    // write, then expect the flush vector for one cycle and zero after
    task automatic wr_chk(logic [1:0] a, logic [31:0] d, logic [2:0] fv, string req);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        step();
        bus_wr = 1'b0;
        push(cyc, KIND_FLUSH, {29'd0, fv}, req);
        step();
        push(cyc, KIND_FLUSH, 32'd0, req);
    endtask

    task automatic rd_chk(logic [1:0] a, logic [31:0] v, string req);
        bus_addr = a;
        push(cyc, KIND_RD, v, req);
        step();
    endtask

    task automatic outs_chk(logic [2:0] v, string req);
        push(cyc, KIND_OUTS, {29'd0, v}, req);
    endtask

    task automatic hits(int n);
        ev_hit = 1'b1;
        repeat (n) step();
        ev_hit = 1'b0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        step(); step();
        // reset state, R2 and R8
        outs_chk(3'b011, "R2 reset outputs");
        push(cyc, KIND_FLUSH, 32'd0, "R3 reset no pulse");
        rd_chk(2'd0, 32'h91, "R2 reset control");
        rd_chk(2'd1, 32'h3, "R8 reset status");
        rst = 1'b0;
        step(); step();
        rd_chk(2'd1, 32'h1, "R8 busy follows idle engine");

        // R3: each flush bit pulses its own output
        wr_chk(2'd0, 32'h99, 3'b001, "R3 cache flush");
        wr_chk(2'd0, 32'hB1, 3'b010, "R3 line flush");
        wr_chk(2'd0, 32'h10091, 3'b100, "R3 port2 flush");
        wr_chk(2'd0, 32'h91, 3'b000, "R3 zero no pulse");
        rd_chk(2'd0, 32'h91, "R2 flush bits read zero");

        // R4: disabling implies flush
        wr_chk(2'd0, 32'h90, 3'b001, "R4 cache disable flush");
        outs_chk(3'b010, "R2 cache disabled");
        rd_chk(2'd0, 32'h90, "R2 readback");
        wr_chk(2'd0, 32'h90, 3'b000, "R4 already disabled");
        wr_chk(2'd0, 32'h81, 3'b010, "R4 line disable flush");
        outs_chk(3'b001, "R2 line disabled");
        wr_chk(2'd0, 32'hC1, 3'b000, "R2 policy set");
        outs_chk(3'b101, "R2 policy output");
        rd_chk(2'd0, 32'hC1, "R2 policy readback");

        // R1: busy drops writes
        eng_busy = 1'b1;
        step(); step();
        rd_chk(2'd1, 32'h3, "R8 busy shown");
        wr_chk(2'd0, 32'h08, 3'b000, "R1 busy write dropped");
        rd_chk(2'd0, 32'hC1, "R1 control unchanged");
        outs_chk(3'b101, "R1 outputs unchanged");
        eng_busy = 1'b0;
        step();
        rd_chk(2'd1, 32'h1, "R8 busy cleared");

        // R8: enabled follows only after busy falls
        bus_addr = 2'd0; bus_wdata = 32'hC0; bus_wr = 1'b1; eng_busy = 1'b1;
        step();
        bus_wr = 1'b0;
        push(cyc, KIND_FLUSH, 32'h1, "R4 disable flush");
        step();
        rd_chk(2'd1, 32'h3, "R8 enabled held while busy");
        rd_chk(2'd0, 32'hC0, "R2 control accepted");
        eng_busy = 1'b0;
        step();
        rd_chk(2'd1, 32'h0, "R8 enabled follows after busy");
        wr_chk(2'd0, 32'h91, 3'b000, "R4 enabling no pulse");
        rd_chk(2'd1, 32'h1, "R8 enabled back");

        // R6: counting
        wr_chk(2'd0, 32'h191, 3'b000, "R5 clear");
        hits(3);
        ev_miss = 1'b1; step(); ev_miss = 1'b0;
        rd_chk(2'd2, 32'd3, "R6 hit count");
        rd_chk(2'd3, 32'd1, "R6 miss count");
        wr_chk(2'd0, 32'h11, 3'b000, "R6 count disable");
        hits(2);
        rd_chk(2'd2, 32'd3, "R6 counting gated");
        wr_chk(2'd0, 32'h91, 3'b000, "R6 count enable");

        // R7: saturation at 4 bits
        hits(20);
        rd_chk(2'd2, 32'd15, "R7 saturated");
        ev_miss = 1'b1; step(); ev_miss = 1'b0;
        rd_chk(2'd3, 32'd2, "R6 miss count");

        // R5: clear beats simultaneous events
        bus_addr = 2'd0; bus_wdata = 32'h191; bus_wr = 1'b1; ev_hit = 1'b1; ev_miss = 1'b1;
        step();
        bus_wr = 1'b0; ev_hit = 1'b0; ev_miss = 1'b0;
        rd_chk(2'd2, 32'd0, "R5 hit cleared");
        rd_chk(2'd3, 32'd0, "R5 miss cleared");
        hits(2);
        wr_chk(2'd0, 32'h91, 3'b000, "R5 no clear bit");
        rd_chk(2'd2, 32'd2, "R5 count kept");

        // R9: other addresses ignore writes
        wr_chk(2'd2, 32'hFFFFFFFF, 3'b000, "R9 write hit addr");
        rd_chk(2'd2, 32'd2, "R9 hit unchanged");
        wr_chk(2'd1, 32'hFFFFFFFF, 3'b000, "R9 write status addr");
        rd_chk(2'd1, 32'h1, "R9 status unchanged");
        wr_chk(2'd3, 32'hFFFFFFFF, 3'b000, "R9 write miss addr");
        rd_chk(2'd3, 32'd0, "R9 miss unchanged");
        rd_chk(2'd0, 32'h91, "R9 control unchanged");
        outs_chk(3'b011, "R9 outputs unchanged");

        step(); step(); step();
        if (sb.size() != 0) begin
            errors++;
            $display("FAIL all requirements: actual %0d pending expected 0", sb.size());
        end
        finish_run();
    end

endmodule